// File: doc/BRIEF.md
# Power-Mode Clock Gating Controller

This block decides, cycle by cycle, which clock enables are live for a processor core, the system clock tree, the oscillators and a vector of peripherals. Software asks for a low-power mode with a one-cycle request pulse and a mode select: select 0 asks for Idle and select 1 asks for Sleep. Idle stops only the core clock. Sleep also stops the system clock and the oscillators, and it keeps only sleep-capable peripherals clocked.

An enabled interrupt, a watchdog time-out or a reset brings the block back to Run. Leaving Idle takes one cycle. Leaving Sleep passes through a Waking state while the oscillators restart, and the core enable returns no later than the eighth cycle after the wake event. Per-peripheral masks refine the gating. A module-disable bit removes a peripheral's clock in every mode. A stop-in-idle bit removes it during Idle only. A selected clock-source code is held across every low-power visit.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset, and on any reset during a low-power mode, the block is in Run: `mode_status`=00, `cpu_clk_en`, `sys_clk_en`, `posc_en`, `aosc_en` and `fscm_en` are 1, `periph_clk_en` equals `~mod_dis`, and `clk_src` equals `RESET_SRC`.
- R2: A peripheral whose `mod_dis` bit is 1 has its `periph_clk_en` bit at 0 in every state, Run included.
- R3: A request pulse with `lp_sel`=0 in Run, with no wake event, gives `mode_status`=01 on the next cycle, with `cpu_clk_en`=0 and `sys_clk_en`, `posc_en`, `aosc_en` and `fscm_en` at 1.
- R4: In Idle, `periph_clk_en` equals `~mod_dis & ~stop_in_idle`.
- R5: A request pulse with `lp_sel`=1 in Run, with no wake event, gives `mode_status`=10 on the next cycle. In that state `cpu_clk_en`, `sys_clk_en`, `posc_en`, `aosc_en` and `fscm_en` are 0, and `periph_clk_en` equals `sleep_cap & ~mod_dis`.
- R6: `lprc_en` equals `wdt_en` in every state.
- R7: A wake event in Idle (`irq_wake` or `wdt_timeout` at 1) returns the block to Run with `cpu_clk_en`=1 on the next cycle.
- R8: A wake event in Sleep gives `mode_status`=11 on the next cycle. That state lasts min(max(`OSC_RESTART`,1),7) cycles and is followed by Run, so `cpu_clk_en` returns within 8 cycles of the wake event. While waking, `cpu_clk_en`=0, the system clock and the oscillators are 1, and `periph_clk_en` equals `~mod_dis`.
- R9: A wake event in the same cycle as a request pulse cancels the entry, and the block stays in Run.
- R10: A request pulse in Idle, Sleep or Waking has no effect on the state.
- R11: `clk_src` loads `src_sel` on a `src_load` pulse only in Run. In every other state it holds, so operation resumes with the source selected before entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_req | input | 1 | One-cycle low-power request |
| lp_sel | input | 1 | 0 = Idle, 1 = Sleep |
| irq_wake | input | 1 | Enabled interrupt pending |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| wdt_en | input | 1 | Watchdog enabled |
| src_load | input | 1 | Load a new clock-source code |
| src_sel | input | SRC_W | Clock-source code to load |
| stop_in_idle | input | NUM_PERIPH | Per-peripheral stop-in-Idle mask |
| mod_dis | input | NUM_PERIPH | Per-peripheral module-disable mask |
| sleep_cap | input | NUM_PERIPH | Peripherals that run in Sleep |
| cpu_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| posc_en | output | 1 | Primary oscillator enable |
| aosc_en | output | 1 | Auxiliary oscillator enable |
| fscm_en | output | 1 | Clock-fail monitor enable |
| lprc_en | output | 1 | Low-power watchdog clock enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| clk_src | output | SRC_W | Held clock-source code |
| mode_status | output | 2 | 00 Run, 01 Idle, 10 Sleep, 11 Waking |

## Verification
The bench builds the block with `NUM_PERIPH`=8, `SRC_W`=3, `RESET_SRC`=1 and `OSC_RESTART`=12. The large restart count drives the Waking length against its cap of seven cycles, so the check that the core enable returns exactly at cycle 8 exercises the worst case of R8. Eight peripherals are enough for mask patterns in which the disable, stop-in-Idle and sleep-capable sets overlap only partly, so every gating rule shows up in the same vector.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10,
        PM_WAKE  = 2'b11
    } pm_state_e;

    typedef struct packed {
        logic cpu;
        logic sys;
        logic posc;
        logic aosc;
        logic fscm;
    } core_en_t;

    localparam int unsigned WAKE_CAP = 7;

    function automatic int unsigned wake_len(input int unsigned restart);
        if (restart == 0)        return 1;
        else if (restart > WAKE_CAP) return WAKE_CAP;
        else                     return restart;
    endfunction

    function automatic core_en_t core_en_for(input pm_state_e s);
        core_en_t e;
        case (s)
            PM_RUN:   e = '{cpu: 1'b1, sys: 1'b1, posc: 1'b1, aosc: 1'b1, fscm: 1'b1};
            PM_IDLE:  e = '{cpu: 1'b0, sys: 1'b1, posc: 1'b1, aosc: 1'b1, fscm: 1'b1};
            PM_SLEEP: e = '{cpu: 1'b0, sys: 1'b0, posc: 1'b0, aosc: 1'b0, fscm: 1'b0};
            default:  e = '{cpu: 1'b0, sys: 1'b1, posc: 1'b1, aosc: 1'b1, fscm: 1'b1};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_gate_pkg::*;
#(
    parameter int unsigned OSC_RESTART = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lp_req,
    input  logic      lp_sel,
    input  logic      wake,
    output pm_state_e state
);
    localparam int unsigned WLEN = wake_len(OSC_RESTART);
    localparam logic [2:0]  WLAST = 3'(WLEN - 1);

    pm_state_e  nxt;
    logic [2:0] wcnt, wcnt_nxt;

    always_comb begin
        nxt      = state;
        wcnt_nxt = wcnt;
        case (state)
            PM_RUN: begin
                if (lp_req && !wake)
                    nxt = lp_sel ? PM_SLEEP : PM_IDLE;
            end
            PM_IDLE: begin
                if (wake) nxt = PM_RUN;
            end
            PM_SLEEP: begin
                if (wake) begin
                    nxt      = PM_WAKE;
                    wcnt_nxt = 3'd0;
                end
            end
            default: begin
                if (wcnt == WLAST) nxt = PM_RUN;
                else               wcnt_nxt = wcnt + 3'd1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PM_RUN;
            wcnt  <= 3'd0;
        end else begin
            state <= nxt;
            wcnt  <= wcnt_nxt;
        end
    end
endmodule

// File: rtl/pwr_gate_map.sv
module pwr_gate_map
    import pwr_gate_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 8
) (
    input  pm_state_e               state,
    input  logic                    wdt_en,
    input  logic [NUM_PERIPH-1:0]   stop_in_idle,
    input  logic [NUM_PERIPH-1:0]   mod_dis,
    input  logic [NUM_PERIPH-1:0]   sleep_cap,
    output core_en_t                core_en,
    output logic                    lprc_en,
    output logic [NUM_PERIPH-1:0]   periph_en
);
    assign core_en = core_en_for(state);
    assign lprc_en = wdt_en;

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_periph
        logic mode_ok;
        always_comb begin
            case (state)
                PM_IDLE:  mode_ok = !stop_in_idle[g];
                PM_SLEEP: mode_ok = sleep_cap[g];
                default:  mode_ok = 1'b1;
            endcase
        end
        assign periph_en[g] = mode_ok && !mod_dis[g];
    end
endmodule

// File: rtl/pwr_src_hold.sv
module pwr_src_hold #(
    parameter int unsigned SRC_W     = 3,
    parameter int unsigned RESET_SRC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_run,
    input  logic             src_load,
    input  logic [SRC_W-1:0] src_sel,
    output logic [SRC_W-1:0] clk_src
);
    always_ff @(posedge clk) begin
        if (rst)                    clk_src <= SRC_W'(RESET_SRC);
        else if (src_load && in_run) clk_src <= src_sel;
    end
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
    import pwr_gate_pkg::*;
#(
    parameter int unsigned NUM_PERIPH  = 8,
    parameter int unsigned SRC_W       = 3,
    parameter int unsigned RESET_SRC   = 1,
    parameter int unsigned OSC_RESTART = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lp_req,
    input  logic                  lp_sel,
    input  logic                  irq_wake,
    input  logic                  wdt_timeout,
    input  logic                  wdt_en,
    input  logic                  src_load,
    input  logic [SRC_W-1:0]      src_sel,
    input  logic [NUM_PERIPH-1:0] stop_in_idle,
    input  logic [NUM_PERIPH-1:0] mod_dis,
    input  logic [NUM_PERIPH-1:0] sleep_cap,
    output logic                  cpu_clk_en,
    output logic                  sys_clk_en,
    output logic                  posc_en,
    output logic                  aosc_en,
    output logic                  fscm_en,
    output logic                  lprc_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic [SRC_W-1:0]      clk_src,
    output logic [1:0]            mode_status
);
    pm_state_e state;
    core_en_t  core_en;
    logic      wake;

    assign wake = irq_wake || wdt_timeout;

    pwr_mode_fsm #(.OSC_RESTART(OSC_RESTART)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .lp_req (lp_req),
        .lp_sel (lp_sel),
        .wake   (wake),
        .state  (state)
    );

    pwr_gate_map #(.NUM_PERIPH(NUM_PERIPH)) u_map (
        .state        (state),
        .wdt_en       (wdt_en),
        .stop_in_idle (stop_in_idle),
        .mod_dis      (mod_dis),
        .sleep_cap    (sleep_cap),
        .core_en      (core_en),
        .lprc_en      (lprc_en),
        .periph_en    (periph_clk_en)
    );

    pwr_src_hold #(.SRC_W(SRC_W), .RESET_SRC(RESET_SRC)) u_src (
        .clk      (clk),
        .rst      (rst),
        .in_run   (state == PM_RUN),
        .src_load (src_load),
        .src_sel  (src_sel),
        .clk_src  (clk_src)
    );

    assign cpu_clk_en  = core_en.cpu;
    assign sys_clk_en  = core_en.sys;
    assign posc_en     = core_en.posc;
    assign aosc_en     = core_en.aosc;
    assign fscm_en     = core_en.fscm;
    assign mode_status = state;
endmodule

// File: rtl/pwr_gate_ctrl_chk.sv
module pwr_gate_ctrl_chk #(
    parameter int unsigned NUM_PERIPH = 8,
    parameter int unsigned SRC_W      = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  lp_req,
    input logic                  irq_wake,
    input logic                  wdt_timeout,
    input logic                  wdt_en,
    input logic                  src_load,
    input logic [NUM_PERIPH-1:0] mod_dis,
    input logic                  cpu_clk_en,
    input logic                  sys_clk_en,
    input logic                  posc_en,
    input logic                  lprc_en,
    input logic [NUM_PERIPH-1:0] periph_clk_en,
    input logic [SRC_W-1:0]      clk_src,
    input logic [1:0]            mode_status
);
    logic       wk;
    logic [3:0] wk_age;
    assign wk = irq_wake || wdt_timeout;

    always_ff @(posedge clk) begin
        if (rst)                                wk_age <= 4'd0;
        else if (mode_status == 2'b10 && wk)    wk_age <= 4'd1;
        else if (mode_status == 2'b11 && wk_age != 4'd0) wk_age <= wk_age + 4'd1;
        else                                    wk_age <= 4'd0;
    end

    // R2
    mod_dis_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (periph_clk_en & mod_dis) == '0);

    // R5
    sleep_gated_chk: assert property (@(posedge clk) disable iff (rst)
        mode_status == 2'b10 |-> (!cpu_clk_en && !sys_clk_en && !posc_en));

    // R3
    idle_gated_chk: assert property (@(posedge clk) disable iff (rst)
        mode_status == 2'b01 |-> (!cpu_clk_en && sys_clk_en));

    // R6
    lprc_follow_chk: assert property (@(posedge clk) disable iff (rst)
        lprc_en == wdt_en);

    // R7
    idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_status == 2'b01 && wk) |=> (mode_status == 2'b00 && cpu_clk_en));

    // R8
    sleep_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_status == 2'b10 && wk) |=> mode_status == 2'b11);

    // R8
    wake_bound_chk: assert property (@(posedge clk) disable iff (rst)
        mode_status == 2'b11 |-> (wk_age != 4'd0 && wk_age <= 4'd7));

    // R9
    cancel_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_status == 2'b00 && lp_req && wk) |=> mode_status == 2'b00);

    // R11
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_status != 2'b00 || !src_load) |=> $stable(clk_src));
endmodule

bind pwr_gate_ctrl pwr_gate_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH), .SRC_W(SRC_W)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .lp_req        (lp_req),
    .irq_wake      (irq_wake),
    .wdt_timeout   (wdt_timeout),
    .wdt_en        (wdt_en),
    .src_load      (src_load),
    .mod_dis       (mod_dis),
    .cpu_clk_en    (cpu_clk_en),
    .sys_clk_en    (sys_clk_en),
    .posc_en       (posc_en),
    .lprc_en       (lprc_en),
    .periph_clk_en (periph_clk_en),
    .clk_src       (clk_src),
    .mode_status   (mode_status)
);

// File: tb/test_pwr_gate_ctrl.sv
module test_pwr_gate_ctrl;
    localparam int NP = 8;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp_req = 0, lp_sel = 0, irq_wake = 0, wdt_timeout = 0, wdt_en = 0, src_load = 0;
    logic [SW-1:0] src_sel = '0;
    logic [NP-1:0] stop_in_idle = 8'h0F, mod_dis = 8'h81, sleep_cap = 8'h30;
    logic cpu_clk_en, sys_clk_en, posc_en, aosc_en, fscm_en, lprc_en;
    logic [NP-1:0] periph_clk_en;
    logic [SW-1:0] clk_src;
    logic [1:0]    mode_status;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pwr_gate_ctrl #(.NUM_PERIPH(NP), .SRC_W(SW), .RESET_SRC(1), .OSC_RESTART(12)) i_pwr_gate_ctrl (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic core_is(input string req, input logic [4:0] exp);
        check(req, {27'd0, cpu_clk_en, sys_clk_en, posc_en, aosc_en, fscm_en}, {27'd0, exp});
    endtask

    task automatic request(input logic sel, input logic wk);
        @(negedge clk);
        lp_sel = sel; lp_req = 1'b1; irq_wake = wk;
        @(negedge clk);
        lp_req = 1'b0; irq_wake = 1'b0;
    endtask

    task automatic wake_pulse(input logic use_wdt);
        @(negedge clk);
        if (use_wdt) wdt_timeout = 1'b1; else irq_wake = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0; irq_wake = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status", mode_status, 2'b00);
        core_is("R1 core", 5'b11111);
        check("R1 periph", periph_clk_en, 8'h7E);
        check("R1 src", clk_src, 3'd1);
        check("R2 run mask", periph_clk_en & mod_dis, 8'h00);
    endtask

    task automatic t_src_load;
        @(negedge clk);
        src_sel = 3'd5; src_load = 1'b1;
        @(negedge clk);
        src_load = 1'b0;
        check("R11 load in run", clk_src, 3'd5);
    endtask

    task automatic t_idle;
        wdt_en = 1'b1;
        request(1'b0, 1'b0);
        check("R3 status", mode_status, 2'b01);
        core_is("R3 core", 5'b01111);
        check("R4 periph", periph_clk_en, 8'h70);
        check("R6 lprc idle", lprc_en, 1'b1);
        request(1'b1, 1'b0);
        check("R10 ignored in idle", mode_status, 2'b01);
        @(negedge clk);
        src_sel = 3'd2; src_load = 1'b1;
        @(negedge clk);
        src_load = 1'b0;
        check("R11 hold in idle", clk_src, 3'd5);
        wake_pulse(1'b1);
        check("R7 wdt exit", mode_status, 2'b00);
        check("R7 cpu back", cpu_clk_en, 1'b1);
        request(1'b0, 1'b0);
        wake_pulse(1'b0);
        check("R7 irq exit", mode_status, 2'b00);
    endtask

    task automatic t_sleep;
        wdt_en = 1'b0;
        request(1'b1, 1'b0);
        check("R5 status", mode_status, 2'b10);
        core_is("R5 core", 5'b00000);
        check("R5 periph", periph_clk_en, 8'h30);
        check("R6 lprc sleep", lprc_en, 1'b0);
        @(negedge clk);
        wdt_en = 1'b1;
        #1;
        check("R6 lprc sleep on", lprc_en, 1'b1);
        request(1'b0, 1'b0);
        check("R10 ignored in sleep", mode_status, 2'b10);
        @(negedge clk);
        irq_wake = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            irq_wake = 1'b0;
            if (k == 2) begin
                core_is("R8 waking core", 5'b01111);
                check("R8 waking periph", periph_clk_en, 8'h7E);
                lp_req = 1'b1; lp_sel = 1'b0;
            end
            if (k == 3) lp_req = 1'b0;
            if (k < 8) check("R8 waking status", mode_status, 2'b11);
            else begin
                check("R8 run at cycle 8", mode_status, 2'b00);
                check("R8 cpu at cycle 8", cpu_clk_en, 1'b1);
            end
        end
        check("R10 ignored in waking", mode_status, 2'b00);
        check("R11 src kept", clk_src, 3'd5);
    endtask

    task automatic t_cancel;
        request(1'b1, 1'b1);
        check("R9 sleep cancelled", mode_status, 2'b00);
        request(1'b0, 1'b1);
        check("R9 idle cancelled", mode_status, 2'b00);
    endtask

    task automatic t_masks;
        @(negedge clk);
        mod_dis = 8'h3C;
        #1;
        check("R2 run new mask", periph_clk_en, 8'hC3);
        request(1'b1, 1'b0);
        check("R2 sleep mask", periph_clk_en, 8'h00);
        wake_pulse(1'b1);
        repeat (7) @(negedge clk);
        check("R8 back to run", mode_status, 2'b00);
    endtask

    task automatic t_reset_exit;
        request(1'b1, 1'b0);
        check("R5 sleep again", mode_status, 2'b10);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset exits sleep", mode_status, 2'b00);
        core_is("R1 reset core", 5'b11111);
        check("R1 reset src", clk_src, 3'd1);
    endtask

    initial begin
        t_reset;
        t_src_load;
        t_idle;
        t_sleep;
        t_cancel;
        t_masks;
        t_reset_exit;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule